// File: doc/BRIEF.md
# Thread Identifier CSR Unit

This block holds the software thread identifier of one hardware thread as a small set of control/status registers. A supervisor view can be read and written from supervisor or machine mode. A user view gives the identifier to less privileged code. Thread-switch code writes the identifier. Trusted entry code reads it to index per-thread data, and it cannot be forged by ordinary compartments. Each stored identifier carries an optional tag bit, so software can tell a freshly installed value from stale contents.

The unit takes one CSR access per cycle. An access carries an address, an operation (read, write, set bits, clear bits), the operand, the current privilege mode and a system-register-access permission bit. It returns read data in the same cycle, a hit flag for addresses it owns, and an illegal-access flag. The flag is left for the surrounding core to turn into a trap. The parameter USER_RW selects the user view. With USER_RW=0 it is a read-only alias of the supervisor value. With USER_RW=1 it is an independent read-write register at a different address. The registers drive no other state, so no access ever stalls.

Operation encoding on `req_op`: 0 = read, 1 = write, 2 = set bits, 3 = clear bits. Privilege encoding on `req_priv`: 0 = user, 1 = supervisor, 3 = machine. Any nonzero code counts as supervisor or above.

Top module: `tid_csr_unit`

## Requirements
- R1: The supervisor identifier sits at address 0x541. A read there from privilege code 1 or above returns the stored value and tag. A read there from user mode (code 0) raises `rsp_illegal`. Whenever `rsp_illegal` is high, `rsp_rdata` and `rsp_rtag` are zero.
- R2: A write-type access to 0x541 changes the register only when the privilege code is nonzero and `req_asr` is 1. Any other write-type access there raises `rsp_illegal` and leaves the value and tag unchanged.
- R3: With USER_RW=0, address 0xC30 is readable from every mode and returns the supervisor value and tag. Every write-type access to 0xC30 raises `rsp_illegal` and changes nothing.
- R4: With USER_RW=1, address 0x020 holds a separate user identifier. It is readable from every mode and writable from every mode while `req_asr` is 1. Without `req_asr`, a write there is illegal. In this mode 0xC30 is not owned, and writes to 0x020 leave the supervisor value alone.
- R5: Write (op 1) replaces the value and tag with the operand. Set (op 2) ORs the operand into them. Clear (op 3) removes the operand's one bits from them.
- R6: A set or clear whose data operand and tag operand are both zero counts as a read only. It is never refused for lack of write permission.
- R7: Reset (active-low `rst_n`) clears every identifier and tag to zero.
- R8: Read data reflects the register in the same cycle as the request. A write becomes visible from the next clock edge, and the cycle of the write returns the old value.
- R9: An address the unit does not own gives `rsp_hit`=0, `rsp_illegal`=0, zero read data and no state change.
- R10: While `req_valid` is 0, all outputs are zero and no register changes, whatever the other request inputs carry.
- R11: With TAG_EN=0, no tag is stored, `rsp_rtag` is always 0, and the tag operand is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | ID_W | Data operand |
| req_wtag | input | 1 | Tag operand |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_asr | input | 1 | System-register-access permission |
| rsp_hit | output | 1 | Address is owned by this unit |
| rsp_rdata | output | ID_W | Read data, before any write of this cycle |
| rsp_rtag | output | 1 | Tag read with the data |
| rsp_illegal | output | 1 | Access refused |

## Verification
On every cycle, the bound checker enforces several rules. A refused access returns zeros and leaves both identifiers unchanged. An idle or unowned request is silent. A legal supervisor write commits exactly the operand one edge later. Zero-operand set and clear are never refused. In alias mode, writes to the user alias are always refused.

The bench's scenarios cover the behaviour that depends on accumulated contents: the OR and AND-NOT arithmetic over a sequence of writes, and alias reads returning what an earlier supervisor write stored. They also cover reset clearing a populated register and the two instances holding separate values in independent mode.

// File: rtl/tid_csr_pkg.sv
package tid_csr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } csr_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int CSR_ADDR_W = 12;

    typedef struct packed {
        logic hit_sup;
        logic hit_usr;
        logic illegal;
        logic we_sup;
        logic we_usr;
    } dec_t;

endpackage

// File: rtl/tid_csr_decode.sv
module tid_csr_decode
    import tid_csr_pkg::*;
#(
    parameter int                    USER_RW     = 0,
    parameter logic [CSR_ADDR_W-1:0] S_ADDR      = 12'h541,
    parameter logic [CSR_ADDR_W-1:0] UALIAS_ADDR = 12'hC30,
    parameter logic [CSR_ADDR_W-1:0] URW_ADDR    = 12'h020
) (
    input  logic                  req_valid,
    input  logic [CSR_ADDR_W-1:0] req_addr,
    input  csr_op_e               req_op,
    input  logic                  operand_zero,
    input  logic [1:0]            req_priv,
    input  logic                  req_asr,
    output dec_t                  dec
);

    localparam logic [CSR_ADDR_W-1:0] USR_ADDR = (USER_RW != 0) ? URW_ADDR : UALIAS_ADDR;

    logic usr_wr_ok;

    generate
        if (USER_RW != 0) begin : g_usr_rw
            assign usr_wr_ok = req_asr;
        end else begin : g_usr_alias
            assign usr_wr_ok = 1'b0;
        end
    endgenerate

    logic writes;
    logic priv_s;
    logic sup_bad;
    logic usr_bad;

    always_comb begin
        writes  = (req_op == OP_WRITE) ||
                  (((req_op == OP_SET) || (req_op == OP_CLR)) && !operand_zero);
        priv_s  = (req_priv != PRIV_U);
        dec.hit_sup = req_valid && (req_addr == S_ADDR);
        dec.hit_usr = req_valid && (req_addr == USR_ADDR);
        sup_bad = !priv_s || (writes && !(priv_s && req_asr));
        usr_bad = writes && !usr_wr_ok;
        dec.illegal = (dec.hit_sup && sup_bad) || (dec.hit_usr && usr_bad);
        dec.we_sup  = dec.hit_sup && writes && !sup_bad;
        dec.we_usr  = dec.hit_usr && writes && !usr_bad;
    end

endmodule

// File: rtl/tid_csr_regs.sv
module tid_csr_regs
    import tid_csr_pkg::*;
#(
    parameter int ID_W    = 32,
    parameter int TAG_EN  = 1,
    parameter int USER_RW = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_sup,
    input  logic            we_usr,
    input  csr_op_e         op,
    input  logic [ID_W-1:0] wdata,
    input  logic            wtag,
    output logic [ID_W-1:0] sup_id,
    output logic            sup_tag,
    output logic [ID_W-1:0] usr_id,
    output logic            usr_tag
);

    typedef struct packed {
        logic [ID_W-1:0] sid;
        logic            stag;
        logic [ID_W-1:0] uid;
        logic            utag;
    } state_t;

    state_t state_d;
    state_t state_q;

    function automatic logic [ID_W-1:0] merge_v(logic [ID_W-1:0] old_v,
                                                 logic [ID_W-1:0] opnd,
                                                 csr_op_e o);
        case (o)
            OP_WRITE: return opnd;
            OP_SET:   return old_v | opnd;
            OP_CLR:   return old_v & ~opnd;
            default:  return old_v;
        endcase
    endfunction

    function automatic logic merge_b(logic old_b, logic opnd, csr_op_e o);
        case (o)
            OP_WRITE: return opnd;
            OP_SET:   return old_b | opnd;
            OP_CLR:   return old_b & ~opnd;
            default:  return old_b;
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        if (we_sup) begin
            state_d.sid  = merge_v(state_q.sid, wdata, op);
            state_d.stag = merge_b(state_q.stag, wtag, op);
        end
        if (we_usr) begin
            state_d.uid  = merge_v(state_q.uid, wdata, op);
            state_d.utag = merge_b(state_q.utag, wtag, op);
        end
        if (TAG_EN == 0) begin
            state_d.stag = 1'b0;
            state_d.utag = 1'b0;
        end
        if (USER_RW == 0) begin
            state_d.uid  = '0;
            state_d.utag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sup_id  = state_q.sid;
    assign sup_tag = state_q.stag;
    assign usr_id  = state_q.uid;
    assign usr_tag = state_q.utag;

endmodule

// File: rtl/tid_csr_unit.sv
module tid_csr_unit
    import tid_csr_pkg::*;
#(
    parameter int          ID_W        = 32,
    parameter int          TAG_EN      = 1,
    parameter int          USER_RW     = 0,
    parameter logic [11:0] S_ADDR      = 12'h541,
    parameter logic [11:0] UALIAS_ADDR = 12'hC30,
    parameter logic [11:0] URW_ADDR    = 12'h020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic [1:0]      req_op,
    input  logic [ID_W-1:0] req_wdata,
    input  logic            req_wtag,
    input  logic [1:0]      req_priv,
    input  logic            req_asr,
    output logic            rsp_hit,
    output logic [ID_W-1:0] rsp_rdata,
    output logic            rsp_rtag,
    output logic            rsp_illegal
);

    csr_op_e         op;
    logic            operand_zero;
    logic            tag_opnd;
    dec_t            dec;
    logic [ID_W-1:0] sup_id;
    logic            sup_tag;
    logic [ID_W-1:0] usr_id;
    logic            usr_tag;

    assign op           = csr_op_e'(req_op);
    assign tag_opnd     = (TAG_EN != 0) ? req_wtag : 1'b0;
    assign operand_zero = (req_wdata == '0) && !tag_opnd;

    tid_csr_decode #(
        .USER_RW     (USER_RW),
        .S_ADDR      (S_ADDR),
        .UALIAS_ADDR (UALIAS_ADDR),
        .URW_ADDR    (URW_ADDR)
    ) u_dec (
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_op       (op),
        .operand_zero (operand_zero),
        .req_priv     (req_priv),
        .req_asr      (req_asr),
        .dec          (dec)
    );

    tid_csr_regs #(
        .ID_W    (ID_W),
        .TAG_EN  (TAG_EN),
        .USER_RW (USER_RW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_sup  (dec.we_sup),
        .we_usr  (dec.we_usr),
        .op      (op),
        .wdata   (req_wdata),
        .wtag    (tag_opnd),
        .sup_id  (sup_id),
        .sup_tag (sup_tag),
        .usr_id  (usr_id),
        .usr_tag (usr_tag)
    );

    logic [ID_W-1:0] view_id;
    logic            view_tag;

    always_comb begin
        view_id  = (USER_RW != 0) ? usr_id  : sup_id;
        view_tag = (USER_RW != 0) ? usr_tag : sup_tag;
        rsp_hit     = dec.hit_sup || dec.hit_usr;
        rsp_illegal = dec.illegal;
        rsp_rdata   = '0;
        rsp_rtag    = 1'b0;
        if (!dec.illegal) begin
            if (dec.hit_sup) begin
                rsp_rdata = sup_id;
                rsp_rtag  = sup_tag;
            end else if (dec.hit_usr) begin
                rsp_rdata = view_id;
                rsp_rtag  = view_tag;
            end
        end
    end

endmodule

// File: rtl/tid_csr_chk.sv
module tid_csr_chk #(
    parameter int          ID_W        = 32,
    parameter int          TAG_EN      = 1,
    parameter int          USER_RW     = 0,
    parameter logic [11:0] S_ADDR      = 12'h541,
    parameter logic [11:0] UALIAS_ADDR = 12'hC30,
    parameter logic [11:0] URW_ADDR    = 12'h020
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [11:0]     req_addr,
    input logic [1:0]      req_op,
    input logic [ID_W-1:0] req_wdata,
    input logic            req_wtag,
    input logic [1:0]      req_priv,
    input logic            req_asr,
    input logic            rsp_hit,
    input logic [ID_W-1:0] rsp_rdata,
    input logic            rsp_rtag,
    input logic            rsp_illegal,
    input logic [ID_W-1:0] s_id,
    input logic            s_tag,
    input logic [ID_W-1:0] u_id,
    input logic            u_tag
);

    assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_rdata == '0) && !rsp_rtag);

    assert_user_sup_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == S_ADDR && req_priv == 2'd0) |-> rsp_illegal);

    assert_refused_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |=> $stable(s_id) && $stable(s_tag) && $stable(u_id) && $stable(u_tag));

    assert_sup_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == S_ADDR && req_op == 2'd1 && req_priv != 2'd0 && req_asr)
        |=> s_id == $past(req_wdata));

    assert_zero_opnd_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr != S_ADDR && req_op[1] && req_wdata == '0 && !req_wtag)
        |-> !rsp_illegal);

    assert_sup_read_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_illegal && req_addr == S_ADDR) |-> rsp_rdata == s_id);

    assert_unowned_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> !rsp_illegal && (rsp_rdata == '0) && !rsp_rtag);

    assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(s_id) && $stable(u_id));

    generate
        if (USER_RW == 0) begin : g_alias_chk
            assert_alias_write_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_addr == UALIAS_ADDR && req_op == 2'd1) |-> rsp_illegal);
        end else begin : g_urw_chk
            assert_user_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_addr == URW_ADDR && req_op == 2'd1 && req_asr)
                |=> (u_id == $past(req_wdata)) && $stable(s_id));
        end
        if (TAG_EN == 0) begin : g_notag_chk
            assert_no_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !rsp_rtag && !s_tag && !u_tag);
        end
    endgenerate

endmodule

bind tid_csr_unit tid_csr_chk #(
    .ID_W        (ID_W),
    .TAG_EN      (TAG_EN),
    .USER_RW     (USER_RW),
    .S_ADDR      (S_ADDR),
    .UALIAS_ADDR (UALIAS_ADDR),
    .URW_ADDR    (URW_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_op      (req_op),
    .req_wdata   (req_wdata),
    .req_wtag    (req_wtag),
    .req_priv    (req_priv),
    .req_asr     (req_asr),
    .rsp_hit     (rsp_hit),
    .rsp_rdata   (rsp_rdata),
    .rsp_rtag    (rsp_rtag),
    .rsp_illegal (rsp_illegal),
    .s_id        (sup_id),
    .s_tag       (sup_tag),
    .u_id        (usr_id),
    .u_tag       (usr_tag)
);

// File: tb/sim_tid_csr_unit.sv
`timescale 1ns/1ps
module sim_tid_csr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_wdata = '0;
    logic        req_wtag = 1'b0;
    logic [1:0]  req_priv = '0;
    logic        req_asr = 1'b0;

    logic        hit0, ill0, rt0;
    logic [31:0] rd0;
    logic        hit1, ill1, rt1;
    logic [31:0] rd1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tid_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_wdata(req_wdata), .req_wtag(req_wtag),
        .req_priv(req_priv), .req_asr(req_asr),
        .rsp_hit(hit0), .rsp_rdata(rd0), .rsp_rtag(rt0), .rsp_illegal(ill0)
    );

    tid_csr_unit #(.TAG_EN(0), .USER_RW(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_wdata(req_wdata), .req_wtag(req_wtag),
        .req_priv(req_priv), .req_asr(req_asr),
        .rsp_hit(hit1), .rsp_rdata(rd1), .rsp_rtag(rt1), .rsp_illegal(ill1)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [1:0]  op;
        logic [31:0] wd;
        logic        wt;
        logic [1:0]  pr;
        logic        asr;
        logic        ehit;
        logic        eill;
        logic [31:0] erd;
        logic        ert;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    // op: 0 read, 1 write, 2 set, 3 clear; priv: 0 U, 1 S, 3 M
    localparam vec_t VECS [NV] = '{
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 8'd7},  // R7
        '{12'h541, 2'd1, 32'h1234_5678, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 8'd8},  // R8
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 1'b1, 8'd1},  // R1
        '{12'hC30, 2'd0, 32'h0,         1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 1'b1, 8'd3},  // R3
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 8'd1},  // R1
        '{12'h541, 2'd1, 32'h0000_FFFF, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 8'd2},  // R2
        '{12'h541, 2'd1, 32'h0000_FFFF, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0,         1'b0, 8'd2},  // R2
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 1'b1, 8'd2},  // R2
        '{12'h541, 2'd2, 32'h0000_00F0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 32'h1234_5678, 1'b1, 8'd5},  // R5
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h1234_56F8, 1'b1, 8'd5},  // R5
        '{12'h541, 2'd3, 32'h1000_0008, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h1234_56F8, 1'b1, 8'd5},  // R5
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0234_56F0, 1'b0, 8'd5},  // R5
        '{12'hC30, 2'd1, 32'h5,         1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 8'd3},  // R3
        '{12'hC30, 2'd2, 32'h0,         1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0234_56F0, 1'b0, 8'd6},  // R6
        '{12'h541, 2'd3, 32'h0,         1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0234_56F0, 1'b0, 8'd6},  // R6
        '{12'hC30, 2'd2, 32'h1,         1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 8'd3},  // R3
        '{12'h020, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd9},  // R9
        '{12'h020, 2'd1, 32'h7,         1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 8'd9},  // R9
        '{12'h541, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0234_56F0, 1'b0, 8'd9},  // R9
        '{12'h123, 2'd1, 32'h9,         1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 8'd9}   // R9
    };

    task automatic drive(logic v, logic [11:0] a, logic [1:0] o, logic [31:0] d,
                         logic t, logic [1:0] p, logic s);
        req_valid = v; req_addr = a; req_op = o; req_wdata = d;
        req_wtag = t; req_priv = p; req_asr = s;
    endtask

    task automatic check(string tag, logic ah, logic ai, logic [31:0] ad, logic at,
                         logic eh, logic ei, logic [31:0] ed, logic et);
        n_checks++;
        if (ah !== eh || ai !== ei || ad !== ed || at !== et) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b ill=%0b rd=%h tag=%0b, expected hit=%0b ill=%0b rd=%h tag=%0b",
                     tag, ah, ai, ad, at, eh, ei, ed, et);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].addr, VECS[i].op, VECS[i].wd, VECS[i].wt, VECS[i].pr, VECS[i].asr);
            #1;
            check($sformatf("R%0d vec %0d", VECS[i].req, i), hit0, ill0, rd0, rt0,
                  VECS[i].ehit, VECS[i].eill, VECS[i].erd, VECS[i].ert);
        end

        // R10: idle request carrying a legal write
        @(negedge clk);
        drive(1'b0, 12'h541, 2'd1, 32'hDEAD_BEEF, 1'b1, 2'd3, 1'b1);
        #1 check("R10 idle outputs", hit0, ill0, rd0, rt0, 1'b0, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        drive(1'b1, 12'h541, 2'd0, 32'h0, 1'b0, 2'd3, 1'b0);
        #1 check("R10 idle no change", hit0, ill0, rd0, rt0, 1'b1, 1'b0, 32'h0234_56F0, 1'b0);

        // R7: reset a populated register
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(1'b1, 12'hC30, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0);
        #1 check("R7 cleared", hit0, ill0, rd0, rt0, 1'b1, 1'b0, 32'h0, 1'b0);

        // R4 / R11: independent user register on u1, no tag storage
        @(negedge clk);
        drive(1'b1, 12'h541, 2'd1, 32'h55, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        drive(1'b1, 12'h020, 2'd1, 32'hABCD, 1'b1, 2'd0, 1'b1);
        #1 check("R4 user write legal", hit1, ill1, rd1, rt1, 1'b1, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        drive(1'b1, 12'h541, 2'd0, 32'h0, 1'b0, 2'd3, 1'b0);
        #1 check("R4 sup separate", hit1, ill1, rd1, rt1, 1'b1, 1'b0, 32'h55, 1'b0);
        check("R11 alias unit keeps tag", hit0, ill0, rd0, rt0, 1'b1, 1'b0, 32'h55, 1'b1);
        @(negedge clk);
        drive(1'b1, 12'h020, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0);
        #1 check("R11 user value no tag", hit1, ill1, rd1, rt1, 1'b1, 1'b0, 32'hABCD, 1'b0);
        @(negedge clk);
        drive(1'b1, 12'h020, 2'd1, 32'h1111, 1'b0, 2'd0, 1'b0);
        #1 check("R4 write without asr", hit1, ill1, rd1, rt1, 1'b1, 1'b1, 32'h0, 1'b0);
        @(negedge clk);
        drive(1'b1, 12'hC30, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0);
        #1 check("R4 alias unowned", hit1, ill1, rd1, rt1, 1'b0, 1'b0, 32'h0, 1'b0);
        check("R3 alias reads sup", hit0, ill0, rd0, rt0, 1'b1, 1'b0, 32'h55, 1'b1);
        @(negedge clk);
        drive(1'b1, 12'h020, 2'd2, 32'h0, 1'b0, 2'd1, 1'b0);
        #1 check("R6 user set zero", hit1, ill1, rd1, rt1, 1'b1, 1'b0, 32'hABCD, 1'b0);

        @(negedge clk);
        drive(1'b0, 12'h0, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule